// File: doc/BRIEF.md
# Signed rounding average unit

This block takes two wide vector operands and returns, lane by lane, the two's-complement average of the paired elements, rounded toward positive infinity. A small size code on each request picks the lane width: 8, 16, 32 or 64 bits. Each lane works independently, and the lane results are packed back into a vector as wide as the operands. By default the vectors are 128 bits, so there are 128/width lanes. Lane 0 sits at the most significant end of the vector.

A request is accepted on any cycle where the valid input is high; the ready output is always high, so the unit takes one request per cycle. One cycle after it accepts a request, the unit raises a single-cycle done pulse. The registered result and the exception flag appear in that same cycle. A size code above 3 is illegal. For an illegal code the unit sets the exception flag and leaves the result register untouched.

Top module: `savg_unit`

## Requirements
- R1: With size code 0, each 8-bit lane of the result equals (a + b + 1) >> 1, computed on the signed lane values, keeping the low 8 bits.
- R2: With size code 1, the same rule applies to every 16-bit lane.
- R3: With size code 2, the same rule applies to every 32-bit lane.
- R4: With size code 3, the same rule applies to the two 64-bit lanes.
- R5: Rounding goes upward. In every lane width, -1 averaged with 0 gives 0, and -3 averaged with 0 gives -1.
- R6: The lane sum never overflows. The most negative value averaged with itself gives the most negative value, the largest value averaged with the most negative gives 0, and the largest value averaged with itself gives the largest value.
- R7: No carry or sign passes between lanes. For example, with 8-bit lanes, 0x80 averaged with 0xFF gives 0xC0 in every lane.
- R8: A size code of 4 to 7 sets the exception output in the done cycle and leaves the result output at its previous value. A legal code clears the exception output in its done cycle.
- R9: The done output pulses for exactly one cycle, in the cycle after each accepted request, and at no other time. Result and exception are valid in that cycle.
- R10: After reset, the result is 0, the exception and done outputs are 0, and ready is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| req_vld | input | 1 | Request valid |
| req_rdy | output | 1 | Request ready (always 1 outside reset) |
| req_size | input | SIZE_W (3) | Lane size code: 0=8, 1=16, 2=32, 3=64 bits, 4..7 illegal |
| op_a | input | DATA_W (128) | First operand vector, lane 0 at the MSB end |
| op_b | input | DATA_W (128) | Second operand vector |
| res | output | DATA_W (128) | Registered packed averages |
| exc | output | 1 | Illegal size code flag, valid with done |
| done | output | 1 | One-cycle pulse marking a new result |

## Verification
The bound checker watches, on every cycle, the handshake timing: done follows exactly the accepted requests, the exception flag matches the size code of the previous request, and the result register holds across an illegal request. It also checks the arithmetic of lane 0 against an independent signed computation for the 8-bit and 64-bit widths. The bench's scoreboard compares whole result vectors against a lane-by-lane reference model for every width. Only those scenarios show the corner values across all lanes, the absence of carries between lanes, the reset state, and the way results and exceptions alternate over back-to-back requests.

// File: rtl/savg_pkg.sv
package savg_pkg;
   // Lane size codes; the numeric value selects the lane width 8 << code.
   typedef enum logic [1:0] {
      SZ_8  = 2'd0,
      SZ_16 = 2'd1,
      SZ_32 = 2'd2,
      SZ_64 = 2'd3
   } lane_sz_e;

   localparam int unsigned NUM_SIZES = 4;
   localparam int unsigned MIN_LANE_W = 8;

   function automatic int unsigned lane_width(input int unsigned code);
      return MIN_LANE_W << code;
   endfunction
endpackage

// File: rtl/savg_lane.sv
// One lane: signed average rounded upward, using a sum one bit wider than the lane.
module savg_lane #(
   parameter int unsigned W = 8
) (
   input  logic [W-1:0] a,
   input  logic [W-1:0] b,
   output logic [W-1:0] y
);
   logic [W:0] sum_w;

   always_comb begin
      sum_w = {a[W-1], a} + {b[W-1], b} + (W+1)'(1);
      y     = sum_w[W:1];
   end
endmodule

// File: rtl/savg_array.sv
// Splits a vector into DATA_W/W lanes, lane 0 at the MSB end.
module savg_array #(
   parameter int unsigned DATA_W = 128,
   parameter int unsigned W      = 8
) (
   input  logic [DATA_W-1:0] va,
   input  logic [DATA_W-1:0] vb,
   output logic [DATA_W-1:0] vy
);
   localparam int unsigned LANES = DATA_W / W;

   if (DATA_W % W != 0) begin : g_bad
      $error("savg_array: DATA_W must be a multiple of the lane width");
   end

   for (genvar i = 0; i < LANES; i++) begin : g_lane
      localparam int unsigned HI = DATA_W - 1 - i * W;
      savg_lane #(.W(W)) u_lane (
         .a (va[HI -: W]),
         .b (vb[HI -: W]),
         .y (vy[HI -: W])
      );
   end
endmodule

// File: rtl/savg_sel.sv
// One lane array per legal width, followed by a select on the size code.
module savg_sel
   import savg_pkg::*;
#(
   parameter int unsigned DATA_W = 128
) (
   input  logic [DATA_W-1:0] va,
   input  logic [DATA_W-1:0] vb,
   input  lane_sz_e          sz,
   output logic [DATA_W-1:0] vy
);
   logic [NUM_SIZES-1:0][DATA_W-1:0] per_w;

   for (genvar k = 0; k < NUM_SIZES; k++) begin : g_width
      savg_array #(.DATA_W(DATA_W), .W(lane_width(k))) u_arr (
         .va (va),
         .vb (vb),
         .vy (per_w[k])
      );
   end

   always_comb vy = per_w[sz];
endmodule

// File: rtl/savg_unit.sv
module savg_unit
   import savg_pkg::*;
#(
   parameter int unsigned DATA_W = 128,
   parameter int unsigned SIZE_W = 3
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              req_vld,
   output logic              req_rdy,
   input  logic [SIZE_W-1:0] req_size,
   input  logic [DATA_W-1:0] op_a,
   input  logic [DATA_W-1:0] op_b,
   output logic [DATA_W-1:0] res,
   output logic              exc,
   output logic              done
);
   localparam int unsigned MAX_W = lane_width(NUM_SIZES - 1);

   if (SIZE_W < 2) begin : g_bad_size
      $error("savg_unit: SIZE_W must be at least 2");
   end
   if (DATA_W % MAX_W != 0) begin : g_bad_data
      $error("savg_unit: DATA_W must be a multiple of the widest lane");
   end

   logic              legal;
   logic              accept;
   logic [DATA_W-1:0] avg_v;

   if (SIZE_W > 2) begin : g_wide_code
      assign legal = ~|req_size[SIZE_W-1:2];
   end else begin : g_narrow_code
      assign legal = 1'b1;
   end

   assign req_rdy = 1'b1;
   assign accept  = req_vld & req_rdy;

   savg_sel #(.DATA_W(DATA_W)) u_sel (
      .va (op_a),
      .vb (op_b),
      .sz (lane_sz_e'(req_size[1:0])),
      .vy (avg_v)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         res  <= '0;
         exc  <= 1'b0;
         done <= 1'b0;
      end else begin
         done <= accept;
         if (accept) begin
            exc <= ~legal;
            if (legal) res <= avg_v;
         end
      end
   end
endmodule

// File: rtl/savg_chk.sv
module savg_chk #(
   parameter int unsigned DATA_W = 128,
   parameter int unsigned SIZE_W = 3
) (
   input logic              clk,
   input logic              rst_n,
   input logic              req_vld,
   input logic              req_rdy,
   input logic [SIZE_W-1:0] req_size,
   input logic [DATA_W-1:0] op_a,
   input logic [DATA_W-1:0] op_b,
   input logic [DATA_W-1:0] res,
   input logic              exc,
   input logic              done
);
   function automatic logic [7:0] ref8(input logic [7:0] x, input logic [7:0] y);
      int s;
      s = int'($signed(x)) + int'($signed(y)) + 1;
      return 8'(s >>> 1);
   endfunction

   function automatic logic [63:0] ref64(input logic [63:0] x, input logic [63:0] y);
      logic signed [65:0] s;
      s = 66'($signed(x)) + 66'($signed(y)) + 66'sd1;
      return 64'(s >>> 1);
   endfunction

   logic acc;
   assign acc = req_vld && req_rdy;

   // R9: a done pulse follows every accepted request
   p_done_after_req_r9: assert property (@(posedge clk) disable iff (!rst_n)
      acc |=> done);

   // R9: no done without a request in the previous cycle
   p_no_stray_done_r9: assert property (@(posedge clk) disable iff (!rst_n)
      !acc |=> !done);

   // R8: exception reflects the legality of the accepted code
   p_exc_code_r8: assert property (@(posedge clk) disable iff (!rst_n)
      acc |=> (exc == ($past(req_size) > 3)));

   // R8: illegal code leaves the result register unchanged
   p_hold_on_exc_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (acc && req_size > 3) |=> $stable(res));

   // R1: lane 0 arithmetic for 8-bit lanes
   p_avg8_lane0_r1: assert property (@(posedge clk) disable iff (!rst_n)
      (acc && req_size == 0) |=>
      (res[DATA_W-1 -: 8] == ref8($past(op_a[DATA_W-1 -: 8]), $past(op_b[DATA_W-1 -: 8]))));

   // R4: lane 0 arithmetic for 64-bit lanes
   p_avg64_lane0_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (acc && req_size == 3) |=>
      (res[DATA_W-1 -: 64] == ref64($past(op_a[DATA_W-1 -: 64]), $past(op_b[DATA_W-1 -: 64]))));
endmodule

bind savg_unit savg_chk #(.DATA_W(DATA_W), .SIZE_W(SIZE_W)) u_chk (
   .clk      (clk),
   .rst_n    (rst_n),
   .req_vld  (req_vld),
   .req_rdy  (req_rdy),
   .req_size (req_size),
   .op_a     (op_a),
   .op_b     (op_b),
   .res      (res),
   .exc      (exc),
   .done     (done)
);

// File: tb/sim_savg_unit.sv
`timescale 1ns/1ps
module sim_savg_unit;
   localparam int unsigned DW = 128;
   localparam int unsigned SW = 3;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          req_vld = 1'b0;
   logic          req_rdy;
   logic [SW-1:0] req_size = '0;
   logic [DW-1:0] op_a = '0;
   logic [DW-1:0] op_b = '0;
   logic [DW-1:0] res;
   logic          exc;
   logic          done;

   always #4 clk = ~clk;   // 125 MHz

   savg_unit #(.DATA_W(DW), .SIZE_W(SW)) u0 (
      .clk(clk), .rst_n(rst_n), .req_vld(req_vld), .req_rdy(req_rdy),
      .req_size(req_size), .op_a(op_a), .op_b(op_b),
      .res(res), .exc(exc), .done(done)
   );

   int checks = 0;
   int errors = 0;
   int issued = 0;
   int seen   = 0;
   bit finished = 1'b0;
   bit monitor_on = 1'b0;

   logic [DW-1:0] q_res[$];
   logic          q_exc[$];
   string         q_tag[$];
   logic [DW-1:0] last_res = '0;

   function automatic logic [DW-1:0] model(input logic [DW-1:0] a, input logic [DW-1:0] b,
                                           input int sz);
      logic [DW-1:0] r;
      int w;
      logic [63:0] mask;
      r = '0;
      w = 8 << sz;
      mask = (w == 64) ? 64'hFFFF_FFFF_FFFF_FFFF : ((64'd1 << w) - 64'd1);
      for (int i = 0; i < DW / w; i++) begin
         logic [63:0] av, bv;
         logic signed [65:0] x, y, s;
         av = 64'(a >> (i * w)) & mask;
         bv = 64'(b >> (i * w)) & mask;
         x = $signed({2'b00, av});
         y = $signed({2'b00, bv});
         if (av[w-1]) x = x - (66'sd1 <<< w);
         if (bv[w-1]) y = y - (66'sd1 <<< w);
         s = (x + y + 66'sd1) >>> 1;
         r = r | (DW'(64'(s) & mask) << (i * w));
      end
      return r;
   endfunction

   function automatic logic [DW-1:0] rep(input logic [63:0] pat, input int sz);
      logic [DW-1:0] r;
      int w;
      r = '0;
      w = 8 << sz;
      for (int i = 0; i < DW / w; i++) r = (r << w) | DW'(pat);
      return r;
   endfunction

   task automatic issue(input logic [DW-1:0] a, input logic [DW-1:0] b,
                        input logic [SW-1:0] sz, input string tag);
      @(negedge clk);
      req_vld  = 1'b1;
      req_size = sz;
      op_a     = a;
      op_b     = b;
      if (sz > 3) begin
         q_res.push_back(last_res);
         q_exc.push_back(1'b1);
      end else begin
         last_res = model(a, b, int'(sz));
         q_res.push_back(last_res);
         q_exc.push_back(1'b0);
      end
      q_tag.push_back(tag);
      issued++;
   endtask

   task automatic idle(input int n);
      @(negedge clk);
      req_vld = 1'b0;
      repeat (n - 1) @(negedge clk);
   endtask

   task automatic summary();
      if (!finished) begin
         finished = 1'b1;
         $display("Result: errors=%0d of %0d checks", errors, checks);
         $finish;
      end
   endtask

   // Monitor: pops expected items as done pulses appear
   always @(negedge clk) begin
      if (monitor_on) begin
         if (done) begin
            seen++;
            checks++;
            if (q_res.size() == 0) begin
               errors++;
               $display("FAIL R9: done with nothing pending, actual done=1 expected done=0");
            end else begin
               logic [DW-1:0] er;
               logic ee;
               string tg;
               er = q_res.pop_front();
               ee = q_exc.pop_front();
               tg = q_tag.pop_front();
               if (res !== er || exc !== ee) begin
                  errors++;
                  $display("FAIL %s: actual res=%h exc=%b expected res=%h exc=%b",
                           tg, res, exc, er, ee);
               end
            end
         end
      end
   end

   // Watchdog
   initial begin
      repeat (20000) @(posedge clk);
      checks++;
      errors++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      summary();
   end

   initial begin
      repeat (3) @(negedge clk);
      // R10: reset state
      checks++;
      if (res !== '0 || exc !== 1'b0 || done !== 1'b0) begin
         errors++;
         $display("FAIL R10: actual res=%h exc=%b done=%b expected 0/0/0", res, exc, done);
      end
      rst_n = 1'b1;
      @(negedge clk);
      checks++;
      if (req_rdy !== 1'b1 || done !== 1'b0) begin
         errors++;
         $display("FAIL R10: actual rdy=%b done=%b expected rdy=1 done=0", req_rdy, done);
      end
      monitor_on = 1'b1;

      // R1..R4: mixed operand patterns per width
      for (int k = 0; k < 3; k++) begin
         issue({$urandom, $urandom, $urandom, $urandom}, {$urandom, $urandom, $urandom, $urandom}, 3'd0, "R1");
         issue({$urandom, $urandom, $urandom, $urandom}, {$urandom, $urandom, $urandom, $urandom}, 3'd1, "R2");
         issue({$urandom, $urandom, $urandom, $urandom}, {$urandom, $urandom, $urandom, $urandom}, 3'd2, "R3");
         issue({$urandom, $urandom, $urandom, $urandom}, {$urandom, $urandom, $urandom, $urandom}, 3'd3, "R4");
      end
      issue(128'h0102_0304_0506_0708_090A_0B0C_0D0E_0F10, 128'h1112_1314_1516_1718_191A_1B1C_1D1E_1F20, 3'd0, "R1");
      idle(2);

      // R5: upward rounding
      for (int s = 0; s < 4; s++) begin
         issue({DW{1'b1}}, '0, SW'(s), "R5");
         issue(rep(64'hFFFF_FFFF_FFFF_FFFD, s), '0, SW'(s), "R5");
      end

      // R6: extremes without overflow
      for (int s = 0; s < 4; s++) begin
         logic [63:0] mn, mx;
         int w;
         w  = 8 << s;
         mn = 64'd1 << (w - 1);
         mx = mn - 64'd1;
         issue(rep(mn, s), rep(mn, s), SW'(s), "R6");
         issue(rep(mx, s), rep(mn, s), SW'(s), "R6");
         issue(rep(mx, s), rep(mx, s), SW'(s), "R6");
      end

      // R7: no carries between lanes
      issue(rep(64'h80, 0), rep(64'hFF, 0), 3'd0, "R7");
      issue(rep(64'hFFFF, 1), rep(64'hFFFF, 1), 3'd1, "R7");
      issue(rep(64'h7FFF_FFFF, 2), rep(64'h0000_0001, 2), 3'd2, "R7");
      idle(2);

      // R8: illegal codes hold result and raise the flag
      issue(128'h1234_5678_9ABC_DEF0_0FED_CBA9_8765_4321, 128'h1111_2222_3333_4444_5555_6666_7777_8888, 3'd2, "R8");
      issue({DW{1'b1}}, {DW{1'b1}}, 3'd4, "R8");
      issue('0, {DW{1'b1}}, 3'd7, "R8");
      issue(128'h5, 128'h3, 3'd0, "R8");
      issue('0, '0, 3'd5, "R8");
      idle(3);

      // R9: every request produced exactly one done
      checks++;
      if (seen != issued || q_res.size() != 0) begin
         errors++;
         $display("FAIL R9: actual done pulses=%0d expected=%0d", seen, issued);
      end
      summary();
   end
endmodule